// File: doc/BRIEF.md
# Cycle-Slip Clock Divider

This block is the oscillator stage of an all-digital phase-locked loop. It halves a fast input clock with one toggling flip-flop and gates that clock with the flip-flop's low phase, so that a following divider sees one output pulse per two input clocks when the loop is idle. A loop filter steers the frequency by sending single pulses on two lines. An advance pulse makes the toggle skip one change after a high phase, which inserts half an output cycle. A retard pulse makes it skip one change after a low phase, which deletes half an output cycle.

Each control line is edge-detected into a pending flag. A flag waits until the toggle reaches the phase in which it can be acted on. An advance and a retard that are pending together cancel each other. When advances arrive back to back, the output is limited to two thirds of the input clock rate. When retards arrive back to back, it falls to one third.

Top module: `idc_cycle_adjust`

## Requirements
- R1: While rst_n is low, toggle_o is 0 and both pending flags are clear.
- R2: With no event pending and no skip in progress, toggle_o inverts on every rising clk edge.
- R3: id_out equals clk AND (NOT toggle_o). It pulses during the clk high phase only while the toggle is low.
- R4: A 0-to-1 transition of carry_i seen at a rising edge sets an advance flag. At the first later edge where the toggle is 1 and no skip is in progress, the toggle goes to 0, stays 0 at the following edge, and the flag clears.
- R5: A 0-to-1 transition of borrow_i sets a retard flag. At the first later edge where the toggle is 0 and no skip is in progress, the toggle goes to 1, stays 1 at the following edge, and the flag clears.
- R6: If both flags are pending at an edge with no skip in progress, both clear and the toggle simply inverts.
- R7: Events on one line spaced exactly three clk periods apart are all serviced. Continuous advances give 20 id_out pulses in 30 clocks (toggle pattern high-low-low). Continuous retards give 10 pulses in 30 clocks (pattern low-high-high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| carry_i | input | 1 | Advance request from the loop filter, acted on at its rising transition |
| borrow_i | input | 1 | Retard request from the loop filter, acted on at its rising transition |
| toggle_o | output | 1 | Current toggle flip-flop state |
| id_out | output | 1 | Gated clock output, clk AND NOT toggle |

## Verification
The assertions assume that rising transitions on any one control line are at least three clock periods apart, which is the spacing needed for no request to be lost. The design checks this spacing with saturating gap counters. The stimulus never pulses the same line sooner than three cycles after its previous pulse. It does pulse both lines in the same cycle, and close together, so that the cancel path is exercised.

// File: rtl/idc_cycle_adjust.sv
module idc_cycle_adjust (
  input  logic clk,
  input  logic rst_n,
  input  logic carry_i,
  input  logic borrow_i,
  output logic toggle_o,
  output logic id_out
);

  logic tff_q, hold_q, pend_c_q, pend_b_q, carry_q, borrow_q;
  logic tff_d, hold_d, clr_c, clr_b;
  logic c_rise, b_rise;

  assign c_rise = carry_i & ~carry_q;
  assign b_rise = borrow_i & ~borrow_q;

  always_comb begin
    tff_d  = ~tff_q;
    hold_d = 1'b0;
    clr_c  = 1'b0;
    clr_b  = 1'b0;
    if (hold_q) begin
      tff_d = tff_q;
    end else if (pend_c_q && pend_b_q) begin
      clr_c = 1'b1;
      clr_b = 1'b1;
    end else if (pend_c_q && tff_q) begin
      hold_d = 1'b1;
      clr_c  = 1'b1;
    end else if (pend_b_q && !tff_q) begin
      hold_d = 1'b1;
      clr_b  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tff_q    <= 1'b0;
      hold_q   <= 1'b0;
      pend_c_q <= 1'b0;
      pend_b_q <= 1'b0;
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
    end else begin
      tff_q    <= tff_d;
      hold_q   <= hold_d;
      pend_c_q <= (pend_c_q & ~clr_c) | c_rise;
      pend_b_q <= (pend_b_q & ~clr_b) | b_rise;
      carry_q  <= carry_i;
      borrow_q <= borrow_i;
    end
  end

  assign toggle_o = tff_q;
  assign id_out   = clk & ~tff_q;

  logic [1:0] age_q, gap_c_q, gap_b_q;
  logic       hist1_q, hist2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q   <= 2'd0;
      gap_c_q <= 2'd3;
      gap_b_q <= 2'd3;
      hist1_q <= 1'b0;
      hist2_q <= 1'b0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      gap_c_q <= c_rise ? 2'd0 : ((gap_c_q == 2'd3) ? 2'd3 : gap_c_q + 2'd1);
      gap_b_q <= b_rise ? 2'd0 : ((gap_b_q == 2'd3) ? 2'd3 : gap_b_q + 2'd1);
      hist1_q <= tff_q;
      hist2_q <= hist1_q;
    end
  end

  p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && !pend_c_q && !pend_b_q) |=> (toggle_o != $past(toggle_o)));

  p_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && pend_c_q && !pend_b_q && toggle_o) |=> (!toggle_o ##1 !toggle_o));

  p_borrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && pend_b_q && !pend_c_q && !toggle_o) |=> (toggle_o ##1 toggle_o));

  p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && pend_c_q && pend_b_q) |=> (toggle_o != $past(toggle_o)));

  p_no_triple_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> !(toggle_o == hist1_q && hist1_q == hist2_q));

  p_carry_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    c_rise |-> (gap_c_q >= 2'd2));

  p_borrow_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    b_rise |-> (gap_b_q >= 2'd2));

endmodule

// File: tb/tb_idc_cycle_adjust.sv
`timescale 1ns/1ps
module tb_idc_cycle_adjust;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic carry_i = 1'b0;
  logic borrow_i = 1'b0;
  logic toggle_o, id_out;

  idc_cycle_adjust dut (.clk(clk), .rst_n(rst_n), .carry_i(carry_i),
    .borrow_i(borrow_i), .toggle_o(toggle_o), .id_out(id_out));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit m_t, m_skip, m_pc, m_pb, m_cp, m_bp;
  string tag = "R2";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t = 0; m_skip = 0; m_pc = 0; m_pb = 0; m_cp = 0; m_bp = 0;
    end else begin
      bit rc, rb;
      rc = carry_i && !m_cp;
      rb = borrow_i && !m_bp;
      m_cp = carry_i;
      m_bp = borrow_i;
      if (m_skip) begin
        m_skip = 0;
      end else if (m_pc && m_pb) begin
        m_pc = 0; m_pb = 0; m_t = !m_t; tag = "R6";
      end else if (m_pc && m_t) begin
        m_pc = 0; m_t = 0; m_skip = 1; tag = "R4";
      end else if (m_pb && !m_t) begin
        m_pb = 0; m_t = 1; m_skip = 1; tag = "R5";
      end else begin
        m_t = !m_t; tag = "R2";
      end
      m_pc = m_pc | rc;
      m_pb = m_pb | rb;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk(toggle_o == m_t, tag, toggle_o, m_t);
      chk(id_out == !m_t, "R3", id_out, !m_t);
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) chk(id_out == 1'b0, "R3", id_out, 0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(0, "watchdog", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit c, input bit b);
    @(negedge clk);
    carry_i = c; borrow_i = b;
    @(negedge clk);
    carry_i = 0; borrow_i = 0;
    idle(2);
  endtask

  task automatic run(input bit c, output int pulses);
    pulses = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      carry_i = c && (i % 3 == 0);
      borrow_i = !c && (i % 3 == 0);
      @(posedge clk); #1;
      if (i >= 30 && id_out) pulses++;
    end
    @(negedge clk);
    carry_i = 0; borrow_i = 0;
  endtask

  initial begin
    int p;
    repeat (3) @(posedge clk);
    #1;
    chk(toggle_o == 1'b0, "R1", toggle_o, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(8);
    pulse(1, 0); idle(5);
    @(negedge clk);
    pulse(1, 0); idle(6);
    pulse(0, 1); idle(5);
    @(negedge clk);
    pulse(0, 1); idle(6);
    pulse(1, 1); idle(6);
    @(negedge clk); carry_i = 1;
    @(negedge clk); carry_i = 0; borrow_i = 1;
    @(negedge clk); borrow_i = 0;
    idle(8);
    run(1, p);
    chk(p == 20, "R7", p, 20);
    idle(8);
    run(0, p);
    chk(p == 10, "R7", p, 10);
    idle(8);
    rst_n = 1'b0;
    #1;
    chk(toggle_o == 1'b0, "R1", toggle_o, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(6);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule